// File: doc/BRIEF.md
# Ultra DMA Data-In Host Controller

This block is the host end of a parallel ATA Ultra DMA read burst. When the surrounding logic raises a start request and the device has raised its DMA request line, the controller grants the burst with an acknowledge. After a mode-dependent delay it raises its ready line. It then takes one 16-bit word from the data bus on every rising and every falling transition of the device strobe. The strobe and data arrive from another clock domain. They are brought into the system clock with two-stage synchronisers, and strobe transitions are found by comparing successive synchronised samples.

Captured words go into a small FIFO and leave on a valid/ready stream. When the FIFO fills past a high-water mark, the ready line drops. The device may still send three more words after that, and the FIFO keeps room for them. Either side can end the burst. The device ends it by dropping its request. The host ends it by raising STOP and then waiting, with no time limit, for the device to drop its request. In both cases the controller holds STOP for a mode-dependent minimum time. It then samples the CRC word the device holds on the bus, compares it with a running CRC over the received words, and releases the acknowledge. Every mode-dependent delay is counted in system clocks.

Top module: `udmaInHost`

## Requirements
- R1: After reset, `dmack`, `hdmardy`, `stop`, `outValid` and `crcErr` are all 0.
- R2: `dmack` rises only while `burstReq` is 1 and `dmarq` has been 1 for at least two clock edges. With `dmarq` at 0, `dmack` stays 0 whatever `burstReq` does.
- R3: `hdmardy` rises exactly W cycles after `dmack` rises. W = ceil(P / CLK_PERIOD_NS), where P is 240, 160, 120, 90, 60 or 40 ns for `modeSel` 0 to 5, and P is 40 ns for `modeSel` 6 and 7. `modeSel` is sampled when the burst is granted.
- R4: During a burst, each rising and each falling transition of `dstrobe` captures the value on `dd` as one word. The words appear on `outData` in arrival order, one per cycle in which `outValid` and `outReady` are both 1, and none is dropped or repeated.
- R5: `hdmardy` is 0 while the FIFO holds FIFO_DEPTH-SLACK or more words (4 of 8 by default). A device that sends at most three words after seeing `hdmardy` at 0 loses no data, and the FIFO is never written while full.
- R6: A 1 on `stopReq` during transfer raises `stop` and forces `hdmardy` to 0. `stop` and `dmack` then stay 1 for as long as `dmarq` stays 1.
- R7: When the device drops `dmarq` during transfer, `stop` goes to 1. It stays 1 for exactly W cycles (W as in R3), and `dmack` falls in the same cycle that `stop` falls.
- R8: The running CRC starts at 16'h4ABA when a burst is granted. Each word d is folded in by taking its bits from bit 15 down to bit 0. For each bit, f = crc[15] ^ d[i], crc is shifted left by one bit, and if f is 1 the result is XORed with 16'h1021. When `dmack` falls, `crcErr` is set to 1 if `dd` differs from the running CRC and to 0 otherwise. It holds that value until the next grant clears it.
- R9: `dstrobe` transitions outside a burst's transfer phase capture nothing: `outValid` stays 0.
- R10: `hdmardy` and `stop` are 1 only while `dmack` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 3 | Transfer mode, 0 to 5 (6 and 7 act as 5) |
| burstReq | input | 1 | Permission from upstream logic to grant a burst |
| stopReq | input | 1 | Upstream request to end the current burst |
| dmarq | input | 1 | Device DMA request |
| dmack | output | 1 | Host DMA acknowledge |
| hdmardy | output | 1 | Host ready to take words (active high) |
| stop | output | 1 | Host request to end the burst |
| dstrobe | input | 1 | Device data strobe; both transitions carry a word |
| dd | input | 16 | Device data bus |
| outData | output | 16 | Captured word |
| outValid | output | 1 | `outData` holds a word |
| outReady | input | 1 | Consumer takes the word this cycle |
| crcErr | output | 1 | CRC mismatch in the last finished burst |

## Verification
A wrong FSM state shows on the three handshake lines within one cycle, because they are decoded directly from state. The bench measures the ready delay and the stop-to-release time cycle by cycle, so an off-by-one in the wait counter or a wrong mode row gives a different count. A corrupted FIFO pointer or a missed strobe transition gives a wrong word, or a missing one, on the very next handshake. A CRC fold error stays hidden until the end of the burst, and then `crcErr` is wrong in the same cycle that `dmack` falls.

// File: rtl/udmaInPkg.sv
package udmaInPkg;

  localparam int unsigned WORD_W = 16;
  localparam logic [WORD_W-1:0] CRC_SEED = 16'h4ABA;
  localparam logic [WORD_W-1:0] CRC_POLY = 16'h1021;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK,
    ST_XFER,
    ST_STOPW,
    ST_ENDW
  } ctlState_t;

  typedef struct packed {
    logic captureEn;
    logic seedCrc;
    logic checkCrc;
  } ctlStrobes_t;

  // Typical two-cycle strobe period per mode, in ns.
  function automatic int unsigned strobePairNs(input logic [2:0] mode);
    case (mode)
      3'd0:    return 240;
      3'd1:    return 160;
      3'd2:    return 120;
      3'd3:    return 90;
      3'd4:    return 60;
      default: return 40;
    endcase
  endfunction

  function automatic int unsigned modeWaitCycles(input logic [2:0] mode,
                                                 input int unsigned clkNs);
    return (strobePairNs(mode) + clkNs - 1) / clkNs;
  endfunction

  function automatic logic [WORD_W-1:0] crcFold(input logic [WORD_W-1:0] crcIn,
                                                input logic [WORD_W-1:0] word);
    logic [WORD_W-1:0] c;
    logic fb;
    c = crcIn;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = c[WORD_W-1] ^ word[i];
      c  = {c[WORD_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return c;
  endfunction

endpackage

// File: rtl/udmaInCtrl.sv
module udmaInCtrl
  import udmaInPkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  modeSel,
  input  logic        burstReq,
  input  logic        stopReq,
  input  logic        dmarq,
  input  logic        almostFull,
  output logic        dmack,
  output logic        hdmardy,
  output logic        stop,
  output ctlStrobes_t ctl
);

  localparam int unsigned MAX_WAIT = modeWaitCycles(3'd0, CLK_PERIOD_NS);
  localparam int unsigned CNT_W    = $clog2(MAX_WAIT + 1);

  ctlState_t state, nextState;
  logic dmarqS1, dmarqS2;
  logic [2:0] modeQ;
  logic [CNT_W-1:0] cnt, waitLimit;
  logic waitDone;

  assign waitLimit = CNT_W'(modeWaitCycles(modeQ, CLK_PERIOD_NS) - 1);
  assign waitDone  = (cnt == waitLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      dmarqS1 <= 1'b0;
      dmarqS2 <= 1'b0;
      cnt     <= '0;
      modeQ   <= '0;
    end else begin
      dmarqS1 <= dmarq;
      dmarqS2 <= dmarqS1;
      state   <= nextState;
      if (state != nextState) cnt <= '0;
      else                    cnt <= cnt + 1'b1;
      if (state == ST_IDLE && nextState == ST_ACK) modeQ <= modeSel;
    end
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    case (state)
      ST_IDLE: begin
        if (burstReq && dmarqS2) begin
          nextState   = ST_ACK;
          ctl.seedCrc = 1'b1;
        end
      end
      ST_ACK: begin
        if (waitDone) nextState = ST_XFER;
      end
      ST_XFER: begin
        ctl.captureEn = 1'b1;
        if (!dmarqS2)     nextState = ST_ENDW;
        else if (stopReq) nextState = ST_STOPW;
      end
      ST_STOPW: begin
        ctl.captureEn = 1'b1;
        if (!dmarqS2) nextState = ST_ENDW;
      end
      ST_ENDW: begin
        if (waitDone) begin
          ctl.checkCrc = 1'b1;
          nextState    = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign dmack   = (state != ST_IDLE);
  assign hdmardy = (state == ST_XFER) && !almostFull;
  assign stop    = (state == ST_STOPW) || (state == ST_ENDW);

endmodule

// File: rtl/udmaInDatapath.sv
module udmaInDatapath
  import udmaInPkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned SLACK      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dstrobe,
  input  logic [WORD_W-1:0] dd,
  input  ctlStrobes_t       ctl,
  output logic [WORD_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady,
  output logic              almostFull,
  output logic              crcErr,
  output logic              pushWord,
  output logic              fifoFull
);

  // FIFO_DEPTH must be a power of two so the pointers wrap naturally.
  localparam int unsigned PTR_W     = $clog2(FIFO_DEPTH);
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1);
  localparam int unsigned HIGH_MARK = FIFO_DEPTH - SLACK;

  logic strS1, strS2, strS3;
  logic [WORD_W-1:0] ddS1, ddS2;
  logic [WORD_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic [WORD_W-1:0] crcQ;
  logic popWord, doPush;

  assign pushWord   = (strS2 ^ strS3) & ctl.captureEn;
  assign fifoFull   = (count == CNT_W'(FIFO_DEPTH));
  assign doPush     = pushWord & ~fifoFull;
  assign outValid   = (count != '0);
  assign popWord    = outValid & outReady;
  assign outData    = mem[rdPtr];
  assign almostFull = (count >= CNT_W'(HIGH_MARK));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strS1 <= 1'b0;
      strS2 <= 1'b0;
      strS3 <= 1'b0;
      ddS1  <= '0;
      ddS2  <= '0;
    end else begin
      strS1 <= dstrobe;
      strS2 <= strS1;
      strS3 <= strS2;
      ddS1  <= dd;
      ddS2  <= ddS1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= ddS2;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush)  wrPtr <= wrPtr + 1'b1;
      if (popWord) rdPtr <= rdPtr + 1'b1;
      count <= count + CNT_W'(doPush) - CNT_W'(popWord);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcQ   <= CRC_SEED;
      crcErr <= 1'b0;
    end else begin
      if (ctl.seedCrc) begin
        crcQ   <= CRC_SEED;
        crcErr <= 1'b0;
      end else if (pushWord) begin
        crcQ <= crcFold(crcQ, ddS2);
      end
      if (ctl.checkCrc) crcErr <= (ddS2 != crcQ);
    end
  end

endmodule

// File: rtl/udmaInHost.sv
module udmaInHost
  import udmaInPkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 5,
  parameter int unsigned FIFO_DEPTH    = 8,
  parameter int unsigned SLACK         = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  modeSel,
  input  logic        burstReq,
  input  logic        stopReq,
  input  logic        dmarq,
  output logic        dmack,
  output logic        hdmardy,
  output logic        stop,
  input  logic        dstrobe,
  input  logic [15:0] dd,
  output logic [15:0] outData,
  output logic        outValid,
  input  logic        outReady,
  output logic        crcErr
);

  ctlStrobes_t ctl;
  logic almostFull;
  logic pushWord;
  logic fifoFull;

  udmaInCtrl #(.CLK_PERIOD_NS(CLK_PERIOD_NS)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .modeSel    (modeSel),
    .burstReq   (burstReq),
    .stopReq    (stopReq),
    .dmarq      (dmarq),
    .almostFull (almostFull),
    .dmack      (dmack),
    .hdmardy    (hdmardy),
    .stop       (stop),
    .ctl        (ctl)
  );

  udmaInDatapath #(.FIFO_DEPTH(FIFO_DEPTH), .SLACK(SLACK)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .dstrobe    (dstrobe),
    .dd         (dd),
    .ctl        (ctl),
    .outData    (outData),
    .outValid   (outValid),
    .outReady   (outReady),
    .almostFull (almostFull),
    .crcErr     (crcErr),
    .pushWord   (pushWord),
    .fifoFull   (fifoFull)
  );

endmodule

// File: rtl/udmaInHostChecker.sv
module udmaInHostChecker (
  input logic clk,
  input logic rstN,
  input logic dmarq,
  input logic dmack,
  input logic hdmardy,
  input logic stop,
  input logic crcErr,
  input logic pushWord,
  input logic fifoFull
);

  p_ready_inside_burst_r10: assert property (@(posedge clk) disable iff (!rstN)
    hdmardy |-> dmack);

  p_stop_inside_burst_r10: assert property (@(posedge clk) disable iff (!rstN)
    stop |-> dmack);

  p_ack_after_request_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmack) |-> $past(dmarq, 2));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    pushWord |-> !fifoFull);

  p_stop_held_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stop && dmack) |=> (stop || !dmack));

  p_not_ready_while_stopping_r6: assert property (@(posedge clk) disable iff (!rstN)
    stop |-> !hdmardy);

  p_crc_flag_steady_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dmack == $past(dmack)) |-> $stable(crcErr));

endmodule

bind udmaInHost udmaInHostChecker chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .dmarq    (dmarq),
  .dmack    (dmack),
  .hdmardy  (hdmardy),
  .stop     (stop),
  .crcErr   (crcErr),
  .pushWord (pushWord),
  .fifoFull (fifoFull)
);

// File: tb/udmaInHost_tb_top.sv
module udmaInHost_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  modeSel = '0;
  logic        burstReq = 1'b0;
  logic        stopReq = 1'b0;
  logic        dmarq = 1'b0;
  logic        dmack, hdmardy, stop;
  logic        dstrobe = 1'b0;
  logic [15:0] dd = '0;
  logic [15:0] outData;
  logic        outValid;
  logic        outReady = 1'b0;
  logic        crcErr;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  logic readyEn = 1'b1;
  logic [15:0] expQ [0:1023];
  int wrIdx = 0;
  int rdIdx = 0;
  logic [15:0] crcB = 16'h4ABA;
  int extra = 0;
  int sentCnt = 0;
  logic sawPause = 1'b0;

  always #2.5 clk = ~clk;

  udmaInHost dut_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .burstReq(burstReq),
    .stopReq(stopReq), .dmarq(dmarq), .dmack(dmack), .hdmardy(hdmardy),
    .stop(stop), .dstrobe(dstrobe), .dd(dd), .outData(outData),
    .outValid(outValid), .outReady(outReady), .crcErr(crcErr)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  function automatic int expW(input int m);
    int ns;
    ns = (m == 0) ? 240 : (m == 1) ? 160 : (m == 2) ? 120 :
         (m == 3) ? 90  : (m == 4) ? 60  : 40;
    return (ns + 4) / 5;
  endfunction

  function automatic logic [15:0] crcNext(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r;
    logic f;
    r = c;
    for (int i = 15; i >= 0; i--) begin
      f = r[15] ^ d[i];
      r = {r[14:0], 1'b0} ^ (f ? 16'h1021 : 16'h0000);
    end
    return r;
  endfunction

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Consumer: drives outReady and checks words in arrival order (R4).
  always @(negedge clk) begin
    outReady = readyEn;
    if (rstN && outValid && outReady) begin
      check(outData == expQ[rdIdx], "R4 word order", int'(outData), int'(expQ[rdIdx]));
      rdIdx++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
      finishRun();
    end
  end

  task automatic startBurst(input int m);
    int n;
    modeSel  = 3'(m);
    dmarq    = 1'b1;
    burstReq = 1'b1;
    crcB     = 16'h4ABA;
    extra    = 0;
    while (!dmack) @(negedge clk);
    burstReq = 1'b0;
    n = 0;
    while (!hdmardy) begin
      @(negedge clk);
      n++;
    end
    check(n == expW(m), "R3 ready delay", n, expW(m));
  endtask

  task automatic sendWord(input logic [15:0] w);
    while (!(hdmardy || extra < 3)) @(negedge clk);
    if (!hdmardy) begin
      extra++;
      sawPause = 1'b1;
    end else begin
      extra = 0;
    end
    dd = w;
    @(negedge clk);
    dstrobe = ~dstrobe;
    expQ[wrIdx] = w;
    wrIdx++;
    sentCnt++;
    crcB = crcNext(crcB, w);
    waitCycles(3);
  endtask

  task automatic deviceEnd(input int m, input logic bad);
    int n;
    dd    = bad ? (crcB ^ 16'h0001) : crcB;
    dmarq = 1'b0;
    while (!stop) @(negedge clk);
    n = 0;
    while (dmack) begin
      @(negedge clk);
      n++;
    end
    check(n == expW(m), "R7 stop-to-release", n, expW(m));
    check(crcErr == bad, "R8 crc flag", int'(crcErr), int'(bad));
    waitCycles(12);
    check(rdIdx == wrIdx, "R4 all words delivered", rdIdx, wrIdx);
    dd = '0;
  endtask

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    @(negedge clk);
    check(!dmack && !hdmardy && !stop, "R1 reset handshake", int'({dmack, hdmardy, stop}), 0);
    check(!outValid && !crcErr, "R1 reset outputs", int'({outValid, crcErr}), 0);

    // R9 / R2: strobe activity and start permission without a device request
    burstReq = 1'b1;
    for (int i = 0; i < 10; i++) begin
      dd = 16'(16'h1111 * i);
      waitCycles(2);
      dstrobe = ~dstrobe;
    end
    waitCycles(6);
    check(!outValid, "R9 idle strobes ignored", int'(outValid), 0);
    check(!dmack, "R2 no grant without dmarq", int'(dmack), 0);
    burstReq = 1'b0;

    // Sweep every mode code: ready delay, transfer, device end with good CRC
    for (int m = 0; m < 8; m++) begin
      startBurst(m);
      for (int k = 0; k < 5 + m; k++) sendWord(16'(m * 16'h0101 + k * 16'h1357));
      check(!stop && dmack, "R10 burst lines in transfer", int'({stop, dmack}), 1);
      deviceEnd(m, 1'b0);
      check(!hdmardy && !stop, "R10 lines low after release", int'({hdmardy, stop}), 0);
    end

    // Bad CRC, then cleared by the next grant (R8)
    startBurst(2);
    for (int k = 0; k < 7; k++) sendWord(16'hF00F ^ 16'(k));
    deviceEnd(2, 1'b1);
    waitCycles(20);
    check(crcErr == 1'b1, "R8 flag held", int'(crcErr), 1);
    startBurst(4);
    check(crcErr == 1'b0, "R8 cleared on grant", int'(crcErr), 0);

    // Backpressure with late words (R5)
    readyEn  = 1'b0;
    sentCnt  = 0;
    sawPause = 1'b0;
    fork
      begin
        for (int k = 0; k < 14; k++) sendWord(16'hA000 + 16'(k * 3));
      end
      begin
        waitCycles(150);
        check(!hdmardy, "R5 ready low when filling", int'(hdmardy), 0);
        check(sentCnt >= 4 && sentCnt <= 8, "R5 words before stall", sentCnt, 8);
        readyEn = 1'b1;
      end
    join
    check(sawPause, "R5 late words sent", int'(sawPause), 1);
    deviceEnd(4, 1'b0);

    // Host-requested end (R6)
    startBurst(1);
    for (int k = 0; k < 4; k++) sendWord(16'h0BAD + 16'(k));
    stopReq = 1'b1;
    while (!stop) @(negedge clk);
    check(!hdmardy, "R6 ready dropped on stop", int'(hdmardy), 0);
    waitCycles(60);
    check(dmack && stop, "R6 wait for device", int'({dmack, stop}), 3);
    dd    = crcB;
    dmarq = 1'b0;
    while (dmack) @(negedge clk);
    stopReq = 1'b0;
    check(!crcErr, "R6 crc after host end", int'(crcErr), 0);
    waitCycles(12);
    check(rdIdx == wrIdx, "R6 words delivered", rdIdx, wrIdx);

    finishRun();
  end

endmodule